// File: doc/BRIEF.md
# Core Nap Wake-up and Clock-Enable Controller

This block runs in the always-on clock domain next to a processor core. It decides when the core's clock may stop and when it must start again. When the core runs its wait-for-interrupt instruction it raises a nap request. The controller compares the fast interrupt lines, its own captured pending bits and the per-source enable mask. If nothing enabled is outstanding, it enters a nap state. The clock-enable drops on the following falling edge of the input clock. As soon as any enabled interrupt or a debug halt request appears, the controller leaves the nap state and the clock-enable rises again on the next falling edge.

Interrupt lines may pulse for a single clock. For that reason every line is captured in an always-on pending flop, which the core later clears with a per-bit clear strobe. The debug halt request is latched in the same way until the core acknowledges it. Wake-up depends only on the per-source mask. Any global interrupt enable plays no part, so the core can resume without taking a trap. A nap request made while an enabled source is already pending is flagged as a skip: the wait instruction then acts as a no-op and the clock never stops.

The enable register changes only on the falling edge, so the AND-type gate on the core clock cannot glitch. A build-time parameter removes the gating entirely.

Top module: `core_nap_ctrl`

## Requirements
- R1: `wake_o` is high in the same cycle whenever any bit of `(irq_i | pend_o) & irq_en_i` is set, or `dbg_req_i` is high, or a debug request is latched. Otherwise it is low. No global interrupt enable takes part.
- R2: A high on `irq_i[i]` for one clock sets `pend_o[i]` from the next cycle on, whether or not the source is enabled and whether or not the core is napping.
- R3: A high on `irq_clr_i[i]` clears `pend_o[i]` on the next cycle, unless `irq_i[i]` is high in that same cycle. In that case the bit stays set.
- R4: `skip_o` is high exactly when `sleep_req_i` and `wake_o` are both high. In that case `napping_o` is low on the next cycle.
- R5: When `sleep_req_i` is high and `wake_o` is low, `napping_o` is high from the next cycle on. It stays high while `wake_o` stays low, even after `sleep_req_i` drops.
- R6: In the first cycle that `wake_o` is high while napping, `napping_o` goes low on the next clock.
- R7: `clk_en_o` is high in reset. It then equals the inverse of `napping_o`, updated only on the falling edge of `clk_i`, half a cycle after `napping_o` changes.
- R8: `core_clk_o` is `clk_i` ANDed with `clk_en_o`. It gives no rising edge while the enable is low.
- R9: A debug request held for one clock is latched. It keeps `wake_o` high until `dbg_ack_i` clears it. A request in the same cycle as the acknowledge wins.
- R10: An interrupt whose enable bit is 0 never wakes the core and never raises the clock-enable, though it is still captured.
- R11: With `GATE_EN` = 0, `clk_en_o` is always 1 and `core_clk_o` follows `clk_i`.
- R12: Reset (`rst_ni` low, asynchronous) clears all pending bits, the debug latch and the nap state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Nap request from the wait instruction |
| irq_i | input | NIRQ | Fast interrupt lines, may be one cycle wide |
| irq_en_i | input | NIRQ | Per-source interrupt enable mask |
| irq_clr_i | input | NIRQ | Per-bit pending clear strobe from the core |
| dbg_req_i | input | 1 | Debug halt request |
| dbg_ack_i | input | 1 | Clears the latched debug request |
| wake_o | output | 1 | Combinational wake indication |
| skip_o | output | 1 | Wait instruction must complete as a no-op |
| napping_o | output | 1 | Nap state |
| pend_o | output | NIRQ | Captured pending interrupt bits |
| clk_en_o | output | 1 | Falling-edge clock-enable register |
| core_clk_o | output | 1 | Gated core clock |

## Verification
The assertions assume that the core does not strobe a clear for a bit it never saw pending. They also assume the core raises `sleep_req_i` only while awake, though the properties stay true if it is held longer. The stimulus drives every input one nanosecond after the rising edge and holds it for the whole cycle, so the falling-edge enable register always sees settled nap state. Clear strobes are mostly applied to bits the bench model holds pending. A few are deliberately made to collide with a new pulse on the same bit. Interrupt pulses are kept sparse and are mostly single-cycle, so that the nap state is entered and left many times during the random phase.

// File: rtl/nap_pkg.sv
package nap_pkg;

  typedef enum logic {
    NAP_AWAKE  = 1'b0,
    NAP_ASLEEP = 1'b1
  } nap_state_e;

  // next nap state: enter on request when nothing wakes, leave on any wake
  function automatic nap_state_e nap_next(nap_state_e cur, logic req, logic wake);
    if (wake)                           return NAP_AWAKE;
    else if (req || cur == NAP_ASLEEP)  return NAP_ASLEEP;
    else                                return NAP_AWAKE;
  endfunction

endpackage

// File: rtl/pend_capture.sv
module pend_capture #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);

  // a new pulse beats a clear in the same cycle
  function automatic logic [WIDTH-1:0] pend_next(logic [WIDTH-1:0] cur,
                                                 logic [WIDTH-1:0] set,
                                                 logic [WIDTH-1:0] clr);
    return set | (cur & ~clr);
  endfunction

  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_next(pend_q, set_i, clr_i);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/nap_fsm.sv
module nap_fsm
  import nap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic wake_i,
  output logic napping_o
);

  nap_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NAP_AWAKE;
    else         state_q <= nap_next(state_q, sleep_req_i, wake_i);
  end

  assign napping_o = (state_q == NAP_ASLEEP);

endmodule

// File: rtl/clk_enable_gate.sv
module clk_enable_gate #(
  parameter bit GATE_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic napping_i,
  output logic clk_en_o,
  output logic core_clk_o
);

  generate
    if (GATE_EN) begin : g_gate
      logic en_q;
      // falling-edge update keeps the AND gate free of glitches
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b1;
        else         en_q <= ~napping_i;
      end
      assign clk_en_o   = en_q;
      assign core_clk_o = clk_i & en_q;
    end else begin : g_bypass
      logic unused_nap;
      assign unused_nap = napping_i ^ rst_ni;
      assign clk_en_o   = 1'b1;
      assign core_clk_o = clk_i;
    end
  endgenerate

endmodule

// File: rtl/core_nap_ctrl.sv
module core_nap_ctrl #(
  parameter int NIRQ    = 32,
  parameter bit GATE_EN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sleep_req_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic [NIRQ-1:0] irq_clr_i,
  input  logic            dbg_req_i,
  input  logic            dbg_ack_i,
  output logic            wake_o,
  output logic            skip_o,
  output logic            napping_o,
  output logic [NIRQ-1:0] pend_o,
  output logic            clk_en_o,
  output logic            core_clk_o
);

  // OR-reduce of enabled live or captured sources, plus debug
  function automatic logic wake_calc(logic [NIRQ-1:0] live,
                                     logic [NIRQ-1:0] held,
                                     logic [NIRQ-1:0] mask,
                                     logic dbg_live, logic dbg_held);
    return (|((live | held) & mask)) | dbg_live | dbg_held;
  endfunction

  logic [NIRQ-1:0] irq_pend;
  logic            dbg_pend;
  logic            irq_wake;
  logic            napping;

  pend_capture #(.WIDTH(NIRQ)) u_irq_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_i),
    .clr_i  (irq_clr_i),
    .pend_o (irq_pend)
  );

  pend_capture #(.WIDTH(1)) u_dbg_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dbg_req_i),
    .clr_i  (dbg_ack_i),
    .pend_o (dbg_pend)
  );

  assign irq_wake = wake_calc(irq_i, irq_pend, irq_en_i, dbg_req_i, dbg_pend);

  nap_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .wake_i      (irq_wake),
    .napping_o   (napping)
  );

  clk_enable_gate #(.GATE_EN(GATE_EN)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .napping_i  (napping),
    .clk_en_o   (clk_en_o),
    .core_clk_o (core_clk_o)
  );

  assign wake_o    = irq_wake;
  assign skip_o    = sleep_req_i & irq_wake;
  assign napping_o = napping;
  assign pend_o    = irq_pend;

endmodule

// File: rtl/core_nap_ctrl_chk.sv
module core_nap_ctrl_chk #(
  parameter int NIRQ    = 32,
  parameter bit GATE_EN = 1'b1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sleep_req_i,
  input logic [NIRQ-1:0] irq_i,
  input logic [NIRQ-1:0] irq_clr_i,
  input logic            dbg_req_i,
  input logic            dbg_ack_i,
  input logic            wake_o,
  input logic            skip_o,
  input logic            napping_o,
  input logic [NIRQ-1:0] pend_o,
  input logic            clk_en_o,
  input logic            dbg_pend
);

  AST_PULSE_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |irq_i |=> ((pend_o & $past(irq_i)) == $past(irq_i))); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(irq_clr_i & ~irq_i) |=> ((pend_o & $past(irq_clr_i & ~irq_i)) == '0)); // R3

  AST_SKIP_NO_NAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> !napping_o); // R4

  AST_NAP_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && !wake_o) |=> napping_o); // R5

  AST_NAP_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(napping_o) |-> $past(sleep_req_i)); // R5

  AST_WAKE_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (napping_o && wake_o) |=> !napping_o); // R6

  AST_EN_TRACKS_NAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GATE_EN ? (clk_en_o == !napping_o) : clk_en_o)); // R7

  AST_DBG_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_i |=> (dbg_pend && wake_o)); // R9

  AST_DBG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_pend && !dbg_ack_i) |=> dbg_pend); // R9

endmodule

bind core_nap_ctrl core_nap_ctrl_chk #(.NIRQ(NIRQ), .GATE_EN(GATE_EN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .irq_i       (irq_i),
  .irq_clr_i   (irq_clr_i),
  .dbg_req_i   (dbg_req_i),
  .dbg_ack_i   (dbg_ack_i),
  .wake_o      (wake_o),
  .skip_o      (skip_o),
  .napping_o   (napping_o),
  .pend_o      (pend_o),
  .clk_en_o    (clk_en_o),
  .dbg_pend    (dbg_pend)
);

// File: tb/test_core_nap_ctrl.sv
module test_core_nap_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sreq = 1'b0, dreq = 1'b0, dack = 1'b0;
  logic [N-1:0] irq = '0, en = '0, clr = '0;
  logic wake, skip, nap, cen, cclk, wake2, skip2, nap2, cen2, cclk2;
  logic [N-1:0] pend, pend2;

  always #2 clk = ~clk; // 250 MHz

  core_nap_ctrl #(.NIRQ(N), .GATE_EN(1'b1)) i_core_nap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sreq), .irq_i(irq), .irq_en_i(en),
    .irq_clr_i(clr), .dbg_req_i(dreq), .dbg_ack_i(dack), .wake_o(wake), .skip_o(skip),
    .napping_o(nap), .pend_o(pend), .clk_en_o(cen), .core_clk_o(cclk));

  core_nap_ctrl #(.NIRQ(N), .GATE_EN(1'b0)) i_core_nap_ctrl_ng (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sreq), .irq_i(irq), .irq_en_i(en),
    .irq_clr_i(clr), .dbg_req_i(dreq), .dbg_ack_i(dack), .wake_o(wake2), .skip_o(skip2),
    .napping_o(nap2), .pend_o(pend2), .clk_en_o(cen2), .core_clk_o(cclk2));

  int checks = 0, fails = 0;
  logic [N-1:0] m_pend = '0;
  logic m_dbg = 1'b0, m_nap = 1'b0, m_nap_prev = 1'b0;

  function automatic logic exp_wake(logic [N-1:0] i, logic [N-1:0] p, logic [N-1:0] e,
                                    logic dr, logic dp);
    logic any = 1'b0;
    for (int b = 0; b < N; b++) if ((i[b] || p[b]) && e[b]) any = 1'b1;
    return any || dr || dp;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive after rising edge, sample after falling edge, advance model
  task automatic step(input logic s, input logic [N-1:0] i, input logic [N-1:0] e,
                      input logic [N-1:0] c, input logic dr, input logic da);
    logic w;
    @(posedge clk); #1;
    chk(cclk == !m_nap_prev, "R8 core clock high phase", N'(cclk), N'(!m_nap_prev));
    chk(cclk2 == 1'b1, "R11 ungated clock high phase", N'(cclk2), N'(1));
    sreq = s; irq = i; en = e; clr = c; dreq = dr; dack = da;
    #2;
    w = exp_wake(i, m_pend, e, dr, m_dbg);
    chk(wake == w, "R1 wake", N'(wake), N'(w));
    chk(skip == (s && w), "R4 skip", N'(skip), N'(s && w));
    chk(nap == m_nap, "R5/R6 nap state", N'(nap), N'(m_nap));
    chk(cen == !m_nap, "R7 clock enable", N'(cen), N'(!m_nap));
    chk(pend == m_pend, "R2/R3 pending", pend, m_pend);
    chk(cen2 == 1'b1 && cclk2 == clk, "R11 no gating", N'(cen2), N'(1));
    m_nap_prev = m_nap;
    m_pend = i | (m_pend & ~c);
    m_dbg  = dr | (m_dbg & ~da);
    m_nap  = w ? 1'b0 : (s || m_nap);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] ones = '1;
    void'($urandom(32'd1234));
    #7;
    // R12 reset state
    chk(nap == 1'b0, "R12 reset nap", N'(nap), N'(0));
    chk(pend == '0, "R12 reset pending", pend, '0);
    chk(cen == 1'b1, "R7 reset enable", N'(cen), N'(1));
    chk(wake == 1'b0, "R12 reset wake", N'(wake), N'(0));
    @(posedge clk); #1; rst_n = 1'b1;

    // R5: enter nap with all sources enabled and quiet
    step(1, '0, ones, '0, 0, 0);
    step(0, '0, ones, '0, 0, 0);
    chk(nap == 1'b1 && cen == 1'b0, "R5 nap entered", N'({nap, cen}), N'(2'b10));
    step(0, '0, ones, '0, 0, 0);
    chk(nap == 1'b1, "R5 nap held", N'(nap), N'(1));

    // R10: masked single-cycle pulse is captured but does not wake
    step(0, N'(1) << 3, ones & ~(N'(1) << 3), '0, 0, 0);
    chk(wake == 1'b0, "R10 masked no wake", N'(wake), N'(0));
    step(0, '0, ones & ~(N'(1) << 3), '0, 0, 0);
    chk(pend[3] && nap && !cen, "R10 masked captured, clock off", N'({pend[3], nap, cen}), N'(3'b110));
    // R3: clear removes it
    step(0, '0, ones & ~(N'(1) << 3), N'(1) << 3, 0, 0);
    step(0, '0, ones & ~(N'(1) << 3), '0, 0, 0);
    chk(pend[3] == 1'b0, "R3 clear", pend, '0);

    // R6: enabled one-cycle pulse wakes, clock back after falling edge
    step(0, N'(1) << 7, N'(1) << 7, '0, 0, 0);
    chk(wake == 1'b1, "R1 pulse wakes", N'(wake), N'(1));
    step(0, '0, N'(1) << 7, '0, 0, 0);
    chk(nap == 1'b0 && cen == 1'b1, "R6 nap left", N'({nap, cen}), N'(2'b01));
    chk(pend[7] == 1'b1, "R2 pulse captured", N'(pend[7]), N'(1));

    // R4: pending enabled bit makes the wait a no-op
    step(1, '0, N'(1) << 7, '0, 0, 0);
    chk(skip == 1'b1, "R4 skip asserted", N'(skip), N'(1));
    step(0, '0, N'(1) << 7, '0, 0, 0);
    chk(nap == 1'b0 && cen == 1'b1, "R4 clock never stopped", N'({nap, cen}), N'(2'b01));

    // R3: clear collides with new pulse, pulse wins
    step(0, N'(1) << 7, '0, N'(1) << 7, 0, 0);
    step(0, '0, '0, '0, 0, 0);
    chk(pend[7] == 1'b1, "R3 pulse beats clear", N'(pend[7]), N'(1));
    step(0, '0, '0, N'(1) << 7, 0, 0);

    // R9: one-cycle debug request while napping
    step(1, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, 1, 0);
    step(0, '0, '0, '0, 0, 0);
    chk(wake == 1'b1 && nap == 1'b0, "R9 debug latched wakes", N'({wake, nap}), N'(2'b10));
    step(0, '0, '0, '0, 0, 1);
    step(0, '0, '0, '0, 0, 0);
    chk(wake == 1'b0, "R9 debug acknowledged", N'(wake), N'(0));

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] ri = '0, rc;
      logic [N-1:0] re = (k % 200 < 100) ? $urandom : N'(32'h0000_00F0);
      if ($urandom_range(9) == 0) ri[$urandom_range(N-1)] = 1'b1;
      rc = m_pend & (($urandom_range(3) == 0) ? $urandom : '0);
      if ($urandom_range(30) == 0) rc = rc | ri;
      step($urandom_range(5) == 0, ri, re, rc, $urandom_range(60) == 0,
           $urandom_range(3) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule